// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Built-In Idle Master

This block chooses which master owns the address phase of a shared AHB bus. It serves a configurable number of real masters (three by default) plus one idle-only master that lives inside the block and occupies slot 0. The grant is one-hot. Two indices come with it: one selects the address and control multiplexer, and the other selects the owner of the data phase, which trails the address owner by one ready cycle. While the idle master owns the bus, the block forces the transfer type seen by the slaves to IDLE.

The idle master has its own request input. This input acts as a pause: whenever it is asserted, every real master below the top one is held off. The block records which masters a slave has answered with SPLIT. Those masters are dropped from arbitration until an external resume bit releases them. The idle master takes the bus in three cases: when a locked sequence is split, when the default master is split and nobody else asks, and when every real master is split.

Top module: `ahb_fixed_arbiter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, grant_o selects master 1 (one-hot bit 1). In that state addr_sel_o and data_sel_o are 1, and split_mask_o is all zero.
- R2: Arbitration at a ready edge follows this order, highest first: the top real master, then the idle master (bit 0), then the remaining real masters in descending index order. Bit k of req_i and grant_o belongs to slot k.
- R3: When no eligible request exists and master 1 is not split, master 1 (the default master) is granted.
- R4: While the idle master holds the grant, htrans_o is IDLE (2'b00). Otherwise htrans_o equals htrans_i.
- R5: grant_o and the select indices change only at a rising edge where hready_i is high. After such an edge, data_sel_o equals the addr_sel_o that held before it.
- R6: grant_o is always exactly one-hot, and addr_sel_o is the index of its set bit.
- R7: When the current owner's lock_i bit is high and the owner is not split, the owner keeps the grant at the next ready edge, whatever the other requests are.
- R8: On an edge where hresp_i is SPLIT (2'b11) and hready_i is low, the split mask bit of the data-phase owner is set. A split_resume_i bit clears its bit on a later edge. While a master's bit is set, that master is not granted even when it requests.
- R9: The idle master is granted when master 1 is split and no other eligible request exists. It is also granted when all real masters are split.
- R10: When a master that was locked in its data phase is split, the idle master holds the grant until that master is resumed, even when higher-priority masters request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_i | input | NUM_MASTERS+1 | Bus requests; bit 0 is the idle master's pause request |
| lock_i | input | NUM_MASTERS+1 | Lock requests, one per slot |
| split_resume_i | input | NUM_MASTERS | Clears the split mask bit of masters 1..NUM_MASTERS |
| hready_i | input | 1 | Shared transfer-done signal |
| hresp_i | input | 2 | Shared slave response |
| htrans_i | input | 2 | Transfer type from the address multiplexer output |
| grant_o | output | NUM_MASTERS+1 | One-hot address-phase grant |
| addr_sel_o | output | clog2(NUM_MASTERS+1) | Index of the address-phase owner |
| data_sel_o | output | clog2(NUM_MASTERS+1) | Index of the data-phase owner |
| htrans_o | output | 2 | Transfer type to slaves, forced IDLE for the idle master |
| split_mask_o | output | NUM_MASTERS | Split state of masters 1..NUM_MASTERS |

## Verification
The bench builds the block with the default of three real masters. With that value every priority relation is in reach: the top master above the pause request, the pause above master 2, and master 2 above the default. The same value lets one sequence split masters 1, 2 and 3 in turn, which drives the mask to all ones and reaches the all-split idle grant. A locked master in the middle of the order is split while the top master requests, to show that the idle hold wins over priority until the resume.

// File: rtl/ahbarb_pkg.sv
`timescale 1ns/1ps
package ahbarb_pkg;
  localparam logic [1:0] TRANS_IDLE = 2'b00;
  localparam logic [1:0] RESP_SPLIT = 2'b11;
  localparam int unsigned MAX_SLOTS = 16;
endpackage

// File: rtl/ahbarb_split_track.sv
`timescale 1ns/1ps
module ahbarb_split_track #(
  parameter int unsigned NUM_MASTERS = 3,
  localparam int unsigned NS   = NUM_MASTERS + 1,
  localparam int unsigned SELW = $clog2(NS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   split_evt_i,
  input  logic [SELW-1:0]        owner_i,
  input  logic                   owner_locked_i,
  input  logic [NUM_MASTERS:1]   resume_i,
  output logic [NS-1:0]          mask_o,
  output logic [NS-1:0]          lsplit_o
);
  // the idle slot never receives a response, so it is never split
  assign mask_o[0]   = 1'b0;
  assign lsplit_o[0] = 1'b0;

  for (genvar g = 1; g < NS; g++) begin : g_slot
    logic hit;
    logic mask_q;
    logic lsplit_q;
    assign hit = split_evt_i && (owner_i == SELW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q   <= 1'b0;
        lsplit_q <= 1'b0;
      end else if (hit) begin
        mask_q   <= 1'b1;
        lsplit_q <= owner_locked_i;
      end else if (resume_i[g]) begin
        mask_q   <= 1'b0;
        lsplit_q <= 1'b0;
      end
    end

    assign mask_o[g]   = mask_q;
    assign lsplit_o[g] = lsplit_q;
  end
endmodule

// File: rtl/ahbarb_prio_pick.sv
`timescale 1ns/1ps
module ahbarb_prio_pick #(
  parameter int unsigned NUM_MASTERS = 3,
  localparam int unsigned NS   = NUM_MASTERS + 1,
  localparam int unsigned SELW = $clog2(NS),
  localparam int unsigned TOP  = NUM_MASTERS
) (
  input  logic [NS-1:0]   req_i,
  input  logic [NS-1:0]   lock_i,
  input  logic [NS-1:0]   mask_i,
  input  logic [NS-1:0]   cur_grant_i,
  input  logic [SELW-1:0] cur_owner_i,
  input  logic            lsplit_any_i,
  output logic [NS-1:0]   next_grant_o,
  output logic            lock_hold_o
);
  // order: TOP, idle slot 0, then TOP-1 down to 1
  function automatic logic [NS-1:0] pick_slot(input logic [NS-1:0] elig);
    logic [NS-1:0] res;
    res = '0;
    if (elig[TOP]) begin
      res[TOP] = 1'b1;
    end else if (elig[0]) begin
      res[0] = 1'b1;
    end else begin
      for (int k = 1; k < int'(TOP); k++) begin
        if (elig[k]) res = '0;
        if (elig[k]) res[k] = 1'b1;
      end
    end
    return res;
  endfunction

  logic [NS-1:0] elig;
  logic [NS-1:0] picked;
  logic [NS-1:0] idle_oh;
  logic [NS-1:0] dflt_oh;

  assign elig        = req_i & ~mask_i;
  assign picked      = pick_slot(elig);
  assign idle_oh     = NS'(1);
  assign dflt_oh     = NS'(2);
  assign lock_hold_o = lock_i[cur_owner_i] && !mask_i[cur_owner_i];

  always_comb begin
    if (lock_hold_o)        next_grant_o = cur_grant_i;
    else if (lsplit_any_i)  next_grant_o = idle_oh;
    else if (|picked)       next_grant_o = picked;
    else if (!mask_i[1])    next_grant_o = dflt_oh;
    else                    next_grant_o = idle_oh;
  end
endmodule

// File: rtl/ahbarb_owner_regs.sv
`timescale 1ns/1ps
module ahbarb_owner_regs #(
  parameter int unsigned NUM_MASTERS = 3,
  localparam int unsigned NS   = NUM_MASTERS + 1,
  localparam int unsigned SELW = $clog2(NS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hready_i,
  input  logic [NS-1:0]   next_grant_i,
  input  logic [NS-1:0]   lock_i,
  output logic [NS-1:0]   grant_o,
  output logic [SELW-1:0] addr_sel_o,
  output logic [SELW-1:0] data_sel_o,
  output logic            data_locked_o
);
  function automatic logic [SELW-1:0] oh_to_idx(input logic [NS-1:0] oh);
    logic [SELW-1:0] idx;
    idx = '0;
    for (int k = 0; k < int'(NS); k++) begin
      if (oh[k]) idx = SELW'(k);
    end
    return idx;
  endfunction

  logic [NS-1:0]   grant_q;
  logic [SELW-1:0] data_q;
  logic            dlock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= NS'(2);
      data_q  <= SELW'(1);
      dlock_q <= 1'b0;
    end else if (hready_i) begin
      grant_q <= next_grant_i;
      data_q  <= oh_to_idx(grant_q);
      dlock_q <= lock_i[oh_to_idx(grant_q)];
    end
  end

  assign grant_o       = grant_q;
  assign addr_sel_o    = oh_to_idx(grant_q);
  assign data_sel_o    = data_q;
  assign data_locked_o = dlock_q;
endmodule

// File: rtl/ahb_fixed_arbiter.sv
`timescale 1ns/1ps
module ahb_fixed_arbiter #(
  parameter int unsigned NUM_MASTERS = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_MASTERS:0]           req_i,
  input  logic [NUM_MASTERS:0]           lock_i,
  input  logic [NUM_MASTERS:1]           split_resume_i,
  input  logic                           hready_i,
  input  logic [1:0]                     hresp_i,
  input  logic [1:0]                     htrans_i,
  output logic [NUM_MASTERS:0]           grant_o,
  output logic [$clog2(NUM_MASTERS+1)-1:0] addr_sel_o,
  output logic [$clog2(NUM_MASTERS+1)-1:0] data_sel_o,
  output logic [1:0]                     htrans_o,
  output logic [NUM_MASTERS:1]           split_mask_o
);
  import ahbarb_pkg::*;
  localparam int unsigned NS   = NUM_MASTERS + 1;
  localparam int unsigned SELW = $clog2(NS);

  // named internal events, observed by the checker
  logic            split_evt_w;
  logic            lock_hold_w;
  logic            lsplit_any_w;
  logic            data_locked_w;
  logic [NS-1:0]   mask_full_w;
  logic [NS-1:0]   lsplit_w;
  logic [NS-1:0]   next_grant_w;

  assign split_evt_w  = (hresp_i == RESP_SPLIT) && !hready_i;
  assign lsplit_any_w = |lsplit_w;

  ahbarb_split_track #(.NUM_MASTERS(NUM_MASTERS)) u_split (
    .clk            (clk),
    .rst_n          (rst_n),
    .split_evt_i    (split_evt_w),
    .owner_i        (data_sel_o),
    .owner_locked_i (data_locked_w),
    .resume_i       (split_resume_i),
    .mask_o         (mask_full_w),
    .lsplit_o       (lsplit_w)
  );

  ahbarb_prio_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
    .req_i        (req_i),
    .lock_i       (lock_i),
    .mask_i       (mask_full_w),
    .cur_grant_i  (grant_o),
    .cur_owner_i  (addr_sel_o),
    .lsplit_any_i (lsplit_any_w),
    .next_grant_o (next_grant_w),
    .lock_hold_o  (lock_hold_w)
  );

  ahbarb_owner_regs #(.NUM_MASTERS(NUM_MASTERS)) u_owner (
    .clk           (clk),
    .rst_n         (rst_n),
    .hready_i      (hready_i),
    .next_grant_i  (next_grant_w),
    .lock_i        (lock_i),
    .grant_o       (grant_o),
    .addr_sel_o    (addr_sel_o),
    .data_sel_o    (data_sel_o),
    .data_locked_o (data_locked_w)
  );

  assign htrans_o     = grant_o[0] ? TRANS_IDLE : htrans_i;
  assign split_mask_o = mask_full_w[NS-1:1];
endmodule

// File: rtl/ahb_fixed_arbiter_chk.sv
`timescale 1ns/1ps
module ahb_fixed_arbiter_chk #(
  parameter int unsigned NUM_MASTERS = 3,
  localparam int unsigned NS   = NUM_MASTERS + 1,
  localparam int unsigned SELW = $clog2(NS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hready_i,
  input logic [1:0]      hresp_i,
  input logic [NS-1:0]   req_i,
  input logic [NS-1:0]   grant_o,
  input logic [SELW-1:0] addr_sel_o,
  input logic [SELW-1:0] data_sel_o,
  input logic [1:0]      htrans_o,
  input logic [NS-1:0]   mask_full_w,
  input logic            lock_hold_w,
  input logic            lsplit_any_w
);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_o) == 1);

  p_sel_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[addr_sel_o]);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_i |=> $stable(grant_o) && $stable(data_sel_o));

  p_data_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hready_i |=> data_sel_o == $past(addr_sel_o));

  p_idle_trans_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[0] |-> htrans_o == 2'b00);

  p_split_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp_i == 2'b11 && !hready_i && data_sel_o != '0) |=> mask_full_w[$past(data_sel_o)]);

  p_top_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hready_i && !lock_hold_w && !lsplit_any_w && req_i[NS-1] && !mask_full_w[NS-1])
      |=> grant_o[NS-1]);

  p_lsplit_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hready_i && lsplit_any_w) |=> grant_o[0]);
endmodule

bind ahb_fixed_arbiter ahb_fixed_arbiter_chk #(.NUM_MASTERS(NUM_MASTERS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .hready_i     (hready_i),
  .hresp_i      (hresp_i),
  .req_i        (req_i),
  .grant_o      (grant_o),
  .addr_sel_o   (addr_sel_o),
  .data_sel_o   (data_sel_o),
  .htrans_o     (htrans_o),
  .mask_full_w  (mask_full_w),
  .lock_hold_w  (lock_hold_w),
  .lsplit_any_w (lsplit_any_w)
);

// File: tb/ahb_fixed_arbiter_tb.sv
`timescale 1ns/1ps
module ahb_fixed_arbiter_tb_top;
  localparam int NM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] lock = '0;
  logic [3:1] resume = '0;
  logic       hready = 1'b1;
  logic [1:0] hresp = 2'b00;
  logic [1:0] htrans = 2'b10;
  logic [3:0] grant;
  logic [1:0] asel;
  logic [1:0] dsel;
  logic [1:0] htrans_out;
  logic [3:1] smask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ahb_fixed_arbiter #(.NUM_MASTERS(NM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock),
    .split_resume_i(resume), .hready_i(hready), .hresp_i(hresp),
    .htrans_i(htrans), .grant_o(grant), .addr_sel_o(asel),
    .data_sel_o(dsel), .htrans_o(htrans_out), .split_mask_o(smask)
  );

  function automatic int idx_of(input logic [3:0] oh);
    int r = 0;
    for (int k = 0; k < 4; k++) if (oh[k]) r = k;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // {req, lock, expected grant}, bit k = slot k, slot 0 = idle master
  localparam logic [11:0] VEC [13] = '{
    {4'b0000, 4'b0000, 4'b0010},
    {4'b0100, 4'b0000, 4'b0100},
    {4'b0110, 4'b0000, 4'b0100},
    {4'b1110, 4'b0000, 4'b1000},
    {4'b1111, 4'b0000, 4'b1000},
    {4'b0111, 4'b0000, 4'b0001},
    {4'b0001, 4'b0000, 4'b0001},
    {4'b0010, 4'b0000, 4'b0010},
    {4'b0100, 4'b0010, 4'b0010},
    {4'b1100, 4'b0010, 4'b0010},
    {4'b1100, 4'b0000, 4'b1000},
    {4'b0100, 4'b1000, 4'b1000},
    {4'b0000, 4'b0000, 4'b0010}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev_g;
    repeat (3) step();
    // R1 reset state
    chk("R1 grant in reset", int'(grant), 2);
    chk("R1 data_sel in reset", int'(dsel), 1);
    chk("R1 mask in reset", int'(smask), 0);
    rst_n = 1'b1;
    step();
    prev_g = 4'b0010;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 13; v++) begin
      req  = VEC[v][11:8];
      lock = VEC[v][7:4];
      step();
      chk($sformatf("R2/R3/R7 grant vec %0d", v), int'(grant), int'(VEC[v][3:0]));
      chk($sformatf("R6 addr_sel vec %0d", v), int'(asel), idx_of(VEC[v][3:0]));
      chk($sformatf("R5 data_sel vec %0d", v), int'(dsel), idx_of(prev_g));
      chk($sformatf("R4 htrans vec %0d", v), int'(htrans_out),
          VEC[v][0] ? 0 : 2);
      prev_g = VEC[v][3:0];
    end

    // R5: no change while not ready
    req = 4'b1000; lock = '0; hready = 1'b0;
    step();
    chk("R5 grant held while not ready", int'(grant), 2);
    chk("R5 data_sel held while not ready", int'(dsel), 3);
    hready = 1'b1;
    step();
    chk("R5 grant after ready", int'(grant), 8);
    chk("R5 data_sel after ready", int'(dsel), 1);
    req = '0;
    step();
    step();
    chk("R3 default back", int'(grant), 2);

    // R8/R9: default master split, nothing else asks
    hresp = 2'b11; hready = 1'b0;
    step();
    chk("R8 mask set on split", int'(smask), 1);
    hready = 1'b1;
    step();
    hresp = 2'b00;
    chk("R9 idle when default split", int'(grant), 1);
    chk("R4 idle transfer forced", int'(htrans_out), 0);
    req = 4'b0010;
    step();
    chk("R8 split master not granted", int'(grant), 1);
    req = 4'b0100;
    step();
    chk("R2 master 2 granted", int'(grant), 4);
    step();
    hresp = 2'b11; hready = 1'b0;
    step();
    chk("R8 mask adds master 2", int'(smask), 3);
    hready = 1'b1; req = 4'b1100;
    step();
    hresp = 2'b00;
    chk("R8 split master 2 skipped", int'(grant), 8);
    step();
    hresp = 2'b11; hready = 1'b0;
    step();
    chk("R8 mask all split", int'(smask), 7);
    hready = 1'b1; req = 4'b1110;
    step();
    hresp = 2'b00;
    chk("R9 idle when all split", int'(grant), 1);
    req = '0; resume = 3'b111;
    step();
    resume = '0;
    chk("R8 resume clears mask", int'(smask), 0);
    step();
    chk("R3 default after resume", int'(grant), 2);

    // R10: locked master split
    req = 4'b0100; lock = 4'b0100;
    step();
    chk("R7 locked master 2 granted", int'(grant), 4);
    step();
    hresp = 2'b11; hready = 1'b0;
    step();
    chk("R8 mask locked split", int'(smask), 2);
    hready = 1'b1; req = 4'b1100;
    step();
    hresp = 2'b00;
    chk("R10 idle on locked split", int'(grant), 1);
    step();
    chk("R10 idle held over top request", int'(grant), 1);
    resume = 3'b010; lock = '0;
    step();
    resume = '0;
    step();
    chk("R10 top master after resume", int'(grant), 8);

    // R1: reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 grant on reset", int'(grant), 2);
    chk("R1 data_sel on reset", int'(dsel), 1);
    chk("R1 mask on reset", int'(smask), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule